// File: doc/BRIEF.md
# PHY Low-Power Entry/Exit Sequencer

This block walks a USB PHY and its controller into a low-power state and back out again, one ordered step at a time. On a suspend request it performs the PHY register accesses that the selected PHY type needs, and asks the PHY to suspend. It waits a bounded time for the PHY to report that it has suspended. It then sets the controller's asynchronous-interrupt and stop bits, applies retention where the configuration calls for it, gates the clocks and drops the supply rails to their low-power settings. A wake event reverses the sequence in a fixed order and re-arms the wake interrupt only after the low-power flag has cleared.

Two configuration inputs choose the step set. `phy_kind` picks between a register-sequenced PHY (type A) and a retention-capable PHY (type B). `ctrl_ext` says whether the OTG function is managed by an external power manager. Both are sampled when a suspend request is accepted and held until the matching exit completes. If the PHY does not confirm suspension within `SUSP_WAIT` cycles, the entry aborts, leaves every clock running and reports the failure with a one-cycle pulse.

Top module: `phy_lpm_sequencer`

## Requirements
- R1: After synchronous reset all four clock enables are 1, `retain_en` is 0, `rail_hpm` and `vdig_floor_hi` are 1, `cmd_async_irq`, `cmd_stop`, `in_lpm`, `phy_lpm_req`, `reg_req` and `entry_fail` are 0, and `wake_irq_en` is 1.
- R2: With `phy_kind`=0 (type A), entry first performs a read (`reg_wr`=0) of address 0x14 and ends its register phase with a write of data 0x08 to address 0x09. With `phy_kind`=1 (type B), entry performs no register access.
- R3: For type A with `ctrl_ext`=0, entry writes data 0x01 to address 0x30 between the 0x14 read and the 0x09 write. With `ctrl_ext`=1 that write is skipped.
- R4: A register access holds `reg_req` high with stable `reg_wr`, `reg_addr` and `reg_wdata` until a cycle with `reg_ack`=1. That cycle completes the access.
- R5: After the register phase `phy_lpm_req` rises, and entry continues only once `phy_susp` is 1.
- R6: If `phy_susp` stays 0 for `SUSP_WAIT` cycles of the wait, entry aborts. `entry_fail` pulses for one cycle, `phy_lpm_req` falls, all clocks stay enabled, `in_lpm` stays 0 and `wake_irq_en` returns to 1.
- R7: On entry `cmd_async_irq` and `cmd_stop` are set before any clock enable falls. The peripheral, core and bus clocks are gated before the source clock.
- R8: For type B with `ctrl_ext`=1, `retain_en` rises before the clocks are gated, and `rail_hpm` then `vdig_floor_hi` fall after the source clock is gated. For every other configuration, retention and the rails are left untouched.
- R9: `in_lpm` rises only after every entry step, with all clocks gated. `wake_irq_en` is 0 while a sequence is running and 1 when the block is at rest.
- R10: On exit the source clock is re-enabled before the other three clocks. For type B with `ctrl_ext`=1, `rail_hpm` and `vdig_floor_hi` are restored before `retain_en` clears.
- R11: On exit the command bits clear, then `in_lpm` falls, and `wake_irq_en` rises in a later cycle than `in_lpm` falls.
- R12: A wake event while not in low power, and a suspend request while in low power, are ignored.
- R13: Changes of `phy_kind` or `ctrl_ext` while in low power do not alter the exit steps, which follow the configuration captured at entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend_req | input | 1 | Request to enter low power |
| wake_evt | input | 1 | Resume or wake event |
| phy_kind | input | 1 | 0 = register-sequenced PHY, 1 = retention-capable PHY |
| ctrl_ext | input | 1 | 1 = OTG managed by external power manager, 0 = by the PHY |
| phy_susp | input | 1 | PHY reports it has suspended |
| reg_ack | input | 1 | Register port completes the current access |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| phy_lpm_req | output | 1 | Asks the PHY to suspend |
| cmd_async_irq | output | 1 | Controller asynchronous-interrupt control bit |
| cmd_stop | output | 1 | Controller interface stop control bit |
| src_clk_en | output | 1 | Source clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| retain_en | output | 1 | PHY retention control |
| rail_hpm | output | 1 | 1 = regulators in high-power mode |
| vdig_floor_hi | output | 1 | 1 = digital supply at normal floor |
| in_lpm | output | 1 | Block is in low power |
| wake_irq_en | output | 1 | Wake interrupt enabled |
| entry_fail | output | 1 | One-cycle pulse on aborted entry |

## Verification
The bench goes after ordering. It timestamps every edge of the clock, retention, rail and flag outputs, and compares the timestamps with one another. A design that gated the source clock first, or cleared retention before the rails were back, would show a reversed pair of timestamps. A design that re-armed the interrupt in the same cycle the flag dropped would show two equal timestamps. A PHY model that never confirms suspension drives the abort path. A design that left clocks gated or the flag set after a timeout would be caught there. Register-access logs are compared per configuration to catch a comparator write issued under external control. A configuration change made while in low power checks that exit still restores retention and rails for the configuration captured at entry.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    typedef enum logic [4:0] {
        ST_ACTIVE,
        EN_LATCH_RD,
        EN_COMP_WR,
        EN_PLL_WR,
        EN_PHY_WAIT,
        EN_CMD,
        EN_RETAIN,
        EN_GATE,
        EN_SRC_OFF,
        EN_RAIL_LO,
        EN_VDIG_LO,
        EN_ABORT,
        ST_LPM,
        EX_SRC_ON,
        EX_CLK_ON,
        EX_RAIL_HI,
        EX_VDIG_HI,
        EX_UNRETAIN,
        EX_CMD_CLR,
        EX_FLAG_CLR,
        EX_IRQ_ON
    } seq_state_e;

    typedef enum logic {
        PHY_KIND_A = 1'b0,
        PHY_KIND_B = 1'b1
    } phy_kind_e;

    typedef struct packed {
        phy_kind_e kind;
        logic      ext;
    } lpm_cfg_t;

    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } reg_op_t;

    typedef struct packed {
        logic src;
        logic periph;
        logic core;
        logic bus;
    } clk_set_t;

    localparam logic [REG_AW-1:0] ADDR_WAKE_LATCH = 8'h14;
    localparam logic [REG_AW-1:0] ADDR_COMP       = 8'h30;
    localparam logic [REG_AW-1:0] ADDR_PLL        = 8'h09;
    localparam logic [REG_DW-1:0] DATA_COMP       = 8'h01;
    localparam logic [REG_DW-1:0] DATA_PLL        = 8'h08;

    function automatic logic uses_regs(lpm_cfg_t c);
        return c.kind == PHY_KIND_A;
    endfunction

    function automatic logic keeps_comparators(lpm_cfg_t c);
        return (c.kind == PHY_KIND_A) && !c.ext;
    endfunction

    function automatic logic uses_retention(lpm_cfg_t c);
        return (c.kind == PHY_KIND_B) && c.ext;
    endfunction

endpackage

// File: rtl/lpm_regport.sv
module lpm_regport
    import lpm_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  reg_op_t op_in,
    input  logic    ack,
    output logic    req,
    output reg_op_t op_q,
    output logic    done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            op_q <= '0;
        end else if (req && ack) begin
            req <= 1'b0;
        end else if (!req && start) begin
            req  <= 1'b1;
            op_q <= op_in;
        end
    end

    assign done = req && ack;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(op_q))); // R4

endmodule

// File: rtl/lpm_susp_timer.sv
module lpm_susp_timer #(
    parameter int SUSP_WAIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic phy_susp,
    output logic timeout
);

    localparam int CW = $clog2(SUSP_WAIT + 1);
    localparam logic [CW-1:0] LAST = CW'(SUSP_WAIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign timeout = run && !phy_susp && (cnt == LAST);

endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       suspend_req,
    input  logic       wake_evt,
    input  lpm_cfg_t   cfg,
    input  logic       reg_done,
    input  logic       susp_ok,
    input  logic       susp_tmo,
    output seq_state_e state,
    output logic       reg_start,
    output reg_op_t    reg_op
);

    seq_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ACTIVE;
        else     state <= nxt;
    end

    always_comb begin
        nxt       = state;
        reg_start = 1'b0;
        reg_op    = '0;
        unique case (state)
            ST_ACTIVE:   if (suspend_req) nxt = EN_LATCH_RD;
            EN_LATCH_RD: begin
                if (uses_regs(cfg)) begin
                    reg_start = 1'b1;
                    reg_op    = '{wr: 1'b0, addr: ADDR_WAKE_LATCH, data: '0};
                    if (reg_done) nxt = EN_COMP_WR;
                end else begin
                    nxt = EN_COMP_WR;
                end
            end
            EN_COMP_WR: begin
                if (keeps_comparators(cfg)) begin
                    reg_start = 1'b1;
                    reg_op    = '{wr: 1'b1, addr: ADDR_COMP, data: DATA_COMP};
                    if (reg_done) nxt = EN_PLL_WR;
                end else begin
                    nxt = EN_PLL_WR;
                end
            end
            EN_PLL_WR: begin
                if (uses_regs(cfg)) begin
                    reg_start = 1'b1;
                    reg_op    = '{wr: 1'b1, addr: ADDR_PLL, data: DATA_PLL};
                    if (reg_done) nxt = EN_PHY_WAIT;
                end else begin
                    nxt = EN_PHY_WAIT;
                end
            end
            EN_PHY_WAIT: begin
                if (susp_ok)       nxt = EN_CMD;
                else if (susp_tmo) nxt = EN_ABORT;
            end
            EN_CMD:      nxt = EN_RETAIN;
            EN_RETAIN:   nxt = EN_GATE;
            EN_GATE:     nxt = EN_SRC_OFF;
            EN_SRC_OFF:  nxt = EN_RAIL_LO;
            EN_RAIL_LO:  nxt = EN_VDIG_LO;
            EN_VDIG_LO:  nxt = ST_LPM;
            EN_ABORT:    nxt = ST_ACTIVE;
            ST_LPM:      if (wake_evt) nxt = EX_SRC_ON;
            EX_SRC_ON:   nxt = EX_CLK_ON;
            EX_CLK_ON:   nxt = EX_RAIL_HI;
            EX_RAIL_HI:  nxt = EX_VDIG_HI;
            EX_VDIG_HI:  nxt = EX_UNRETAIN;
            EX_UNRETAIN: nxt = EX_CMD_CLR;
            EX_CMD_CLR:  nxt = EX_FLAG_CLR;
            EX_FLAG_CLR: nxt = EX_IRQ_ON;
            EX_IRQ_ON:   nxt = ST_ACTIVE;
            default:     nxt = ST_ACTIVE;
        endcase
    end

    AST_LPM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LPM && !wake_evt) |=> (state == ST_LPM)); // R12

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && !suspend_req) |=> (state == ST_ACTIVE)); // R12

endmodule

// File: rtl/phy_lpm_sequencer.sv
module phy_lpm_sequencer
    import lpm_seq_pkg::*;
#(
    parameter int SUSP_WAIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              suspend_req,
    input  logic              wake_evt,
    input  logic              phy_kind,
    input  logic              ctrl_ext,
    input  logic              phy_susp,
    input  logic              reg_ack,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [REG_AW-1:0] reg_addr,
    output logic [REG_DW-1:0] reg_wdata,
    output logic              phy_lpm_req,
    output logic              cmd_async_irq,
    output logic              cmd_stop,
    output logic              src_clk_en,
    output logic              periph_clk_en,
    output logic              core_clk_en,
    output logic              bus_clk_en,
    output logic              retain_en,
    output logic              rail_hpm,
    output logic              vdig_floor_hi,
    output logic              in_lpm,
    output logic              wake_irq_en,
    output logic              entry_fail
);

    seq_state_e state;
    lpm_cfg_t   cfg_q;
    clk_set_t   clk_q;
    reg_op_t    fsm_op;
    reg_op_t    port_op;
    logic       reg_start;
    logic       reg_done;
    logic       susp_tmo;
    logic       susp_ok;
    logic       lpm_req_q;

    assign susp_ok = phy_susp && lpm_req_q;

    lpm_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .suspend_req (suspend_req),
        .wake_evt    (wake_evt),
        .cfg         (cfg_q),
        .reg_done    (reg_done),
        .susp_ok     (susp_ok),
        .susp_tmo    (susp_tmo),
        .state       (state),
        .reg_start   (reg_start),
        .reg_op      (fsm_op)
    );

    lpm_regport u_port (
        .clk   (clk),
        .rst   (rst),
        .start (reg_start),
        .op_in (fsm_op),
        .ack   (reg_ack),
        .req   (reg_req),
        .op_q  (port_op),
        .done  (reg_done)
    );

    lpm_susp_timer #(.SUSP_WAIT(SUSP_WAIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (state == EN_PHY_WAIT),
        .phy_susp (susp_ok),
        .timeout  (susp_tmo)
    );

    // configuration capture at suspend acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{kind: PHY_KIND_A, ext: 1'b0};
        end else if (state == ST_ACTIVE && suspend_req) begin
            cfg_q <= '{kind: phy_kind_e'(phy_kind), ext: ctrl_ext};
        end
    end

    // step actions
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q         <= '{src: 1'b1, periph: 1'b1, core: 1'b1, bus: 1'b1};
            cmd_async_irq <= 1'b0;
            cmd_stop      <= 1'b0;
            retain_en     <= 1'b0;
            rail_hpm      <= 1'b1;
            vdig_floor_hi <= 1'b1;
            in_lpm        <= 1'b0;
            wake_irq_en   <= 1'b1;
            lpm_req_q     <= 1'b0;
            entry_fail    <= 1'b0;
        end else begin
            entry_fail <= 1'b0;
            unique case (state)
                ST_ACTIVE:   if (suspend_req) wake_irq_en <= 1'b0;
                EN_PHY_WAIT: lpm_req_q <= 1'b1;
                EN_CMD: begin
                    cmd_async_irq <= 1'b1;
                    cmd_stop      <= 1'b1;
                end
                EN_RETAIN:   if (uses_retention(cfg_q)) retain_en <= 1'b1;
                EN_GATE: begin
                    clk_q.periph <= 1'b0;
                    clk_q.core   <= 1'b0;
                    clk_q.bus    <= 1'b0;
                end
                EN_SRC_OFF:  clk_q.src <= 1'b0;
                EN_RAIL_LO:  if (uses_retention(cfg_q)) rail_hpm <= 1'b0;
                EN_VDIG_LO: begin
                    if (uses_retention(cfg_q)) vdig_floor_hi <= 1'b0;
                    in_lpm      <= 1'b1;
                    wake_irq_en <= 1'b1;
                end
                EN_ABORT: begin
                    lpm_req_q   <= 1'b0;
                    wake_irq_en <= 1'b1;
                    entry_fail  <= 1'b1;
                    clk_q       <= '{src: 1'b1, periph: 1'b1, core: 1'b1, bus: 1'b1};
                end
                ST_LPM:      if (wake_evt) wake_irq_en <= 1'b0;
                EX_SRC_ON:   clk_q.src <= 1'b1;
                EX_CLK_ON: begin
                    clk_q.periph <= 1'b1;
                    clk_q.core   <= 1'b1;
                    clk_q.bus    <= 1'b1;
                end
                EX_RAIL_HI:  rail_hpm <= 1'b1;
                EX_VDIG_HI:  vdig_floor_hi <= 1'b1;
                EX_UNRETAIN: retain_en <= 1'b0;
                EX_CMD_CLR: begin
                    cmd_async_irq <= 1'b0;
                    cmd_stop      <= 1'b0;
                    lpm_req_q     <= 1'b0;
                end
                EX_FLAG_CLR: in_lpm <= 1'b0;
                EX_IRQ_ON:   wake_irq_en <= 1'b1;
                default: ;
            endcase
        end
    end

    assign reg_wr        = port_op.wr;
    assign reg_addr      = port_op.addr;
    assign reg_wdata     = port_op.data;
    assign phy_lpm_req   = lpm_req_q;
    assign src_clk_en    = clk_q.src;
    assign periph_clk_en = clk_q.periph;
    assign core_clk_en   = clk_q.core;
    assign bus_clk_en    = clk_q.bus;

    AST_CMD_BEFORE_GATE: assert property (@(posedge clk) disable iff (rst)
        $fell(periph_clk_en) |-> (cmd_stop && cmd_async_irq)); // R7
    AST_SRC_LAST_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(src_clk_en) |-> (!periph_clk_en && !core_clk_en && !bus_clk_en)); // R7
    AST_RET_BEFORE_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(retain_en) |-> periph_clk_en); // R8
    AST_RAIL_AFTER_GATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rail_hpm) |-> !src_clk_en); // R8
    AST_LPM_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
        (in_lpm && wake_irq_en) |-> !(src_clk_en || periph_clk_en)); // R9
    AST_SRC_FIRST_ON: assert property (@(posedge clk) disable iff (rst)
        $rose(periph_clk_en) |-> src_clk_en); // R10
    AST_RAIL_BEFORE_UNRET: assert property (@(posedge clk) disable iff (rst)
        $fell(retain_en) |-> (rail_hpm && vdig_floor_hi)); // R10
    AST_FLAG_BEFORE_IRQ: assert property (@(posedge clk) disable iff (rst)
        $fell(in_lpm) |-> !wake_irq_en); // R11
    AST_FAIL_SAFE: assert property (@(posedge clk) disable iff (rst)
        entry_fail |-> (!in_lpm && src_clk_en && periph_clk_en && !phy_lpm_req)); // R6

endmodule

// File: tb/phy_lpm_sequencer_test.sv
module phy_lpm_sequencer_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic suspend_req = 1'b0, wake_evt = 1'b0, phy_kind = 1'b0, ctrl_ext = 1'b0;
    logic phy_susp = 1'b0, reg_ack = 1'b0;
    logic reg_req, reg_wr, phy_lpm_req, cmd_async_irq, cmd_stop;
    logic [7:0] reg_addr, reg_wdata;
    logic src_clk_en, periph_clk_en, core_clk_en, bus_clk_en;
    logic retain_en, rail_hpm, vdig_floor_hi, in_lpm, wake_irq_en, entry_fail;

    localparam int WAIT = 32;
    localparam int ACK_LAT = 3;

    always #4 clk = ~clk;

    phy_lpm_sequencer #(.SUSP_WAIT(WAIT)) uut (.*);

    int tests = 0, fails = 0, cyc = 0;
    int susp_delay = 2;
    int ack_cnt = 0, scnt = 0, nlog = 0, hold_err = 0;
    logic [16:0] log_ops [8];
    logic [16:0] first_op;

    // event timestamps
    int t_cmd_on, t_ret_on, t_per_off, t_src_off, t_rail_off, t_vdig_off, t_lpm_on;
    int t_src_on, t_per_on, t_rail_on, t_vdig_on, t_ret_off, t_cmd_off, t_lpm_off, t_irq_on;
    bit fail_seen;
    logic p_cmd, p_ret, p_per, p_src, p_rail, p_vdig, p_lpm, p_irq;

    task automatic clear_stamps();
        t_cmd_on = -1; t_ret_on = -1; t_per_off = -1; t_src_off = -1;
        t_rail_off = -1; t_vdig_off = -1; t_lpm_on = -1;
        t_src_on = -1; t_per_on = -1; t_rail_on = -1; t_vdig_on = -1;
        t_ret_off = -1; t_cmd_off = -1; t_lpm_off = -1; t_irq_on = -1;
        fail_seen = 0; nlog = 0;
    endtask

    function automatic void stamp(logic p, logic c, ref int rise, ref int fall);
        if (!p && c && rise < 0) rise = cyc;
        if (p && !c && fall < 0) fall = cyc;
    endfunction

    // PHY / register-port model, driven away from the active edge
    always @(negedge clk) begin
        int dummy;
        cyc++;
        if (!rst) begin
            stamp(p_cmd, cmd_stop, t_cmd_on, t_cmd_off);
            stamp(p_ret, retain_en, t_ret_on, t_ret_off);
            stamp(p_per, periph_clk_en, t_per_on, t_per_off);
            stamp(p_src, src_clk_en, t_src_on, t_src_off);
            stamp(p_rail, rail_hpm, t_rail_on, t_rail_off);
            stamp(p_vdig, vdig_floor_hi, t_vdig_on, t_vdig_off);
            stamp(p_lpm, in_lpm, t_lpm_on, t_lpm_off);
            dummy = -1;
            stamp(p_irq, wake_irq_en, t_irq_on, dummy);
            if (entry_fail) fail_seen = 1;
        end
        p_cmd = cmd_stop; p_ret = retain_en; p_per = periph_clk_en; p_src = src_clk_en;
        p_rail = rail_hpm; p_vdig = vdig_floor_hi; p_lpm = in_lpm; p_irq = wake_irq_en;

        if (reg_ack) begin
            reg_ack <= 1'b0;
            ack_cnt = 0;
        end else if (reg_req) begin
            if (ack_cnt == 0) first_op = {reg_wr, reg_addr, reg_wdata};
            else if (first_op != {reg_wr, reg_addr, reg_wdata}) hold_err++;
            ack_cnt++;
            if (ack_cnt == ACK_LAT) begin
                reg_ack <= 1'b1;
                if (nlog < 8) log_ops[nlog] = {reg_wr, reg_addr, reg_wdata};
                nlog++;
            end
        end else begin
            ack_cnt = 0;
        end

        if (phy_lpm_req) begin
            scnt++;
            phy_susp <= (scnt >= susp_delay);
        end else begin
            scnt = 0;
            phy_susp <= 1'b0;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic wait_entry_end();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((in_lpm && wake_irq_en) || fail_seen) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_exit_end();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (t_irq_on >= 0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_reg_log(bit kind, bit ext);
        int exp_n = (kind == 1'b0) ? (ext ? 2 : 3) : 0;
        chk(nlog == exp_n, "R2", "register access count", nlog, exp_n);
        if (kind == 1'b0 && nlog == exp_n) begin
            chk(log_ops[0] == {1'b0, 8'h14, 8'h00}, "R2", "first access read 0x14",
                int'(log_ops[0]), int'({1'b0, 8'h14, 8'h00}));
            chk(log_ops[exp_n-1] == {1'b1, 8'h09, 8'h08}, "R2", "last access 0x08 to 0x09",
                int'(log_ops[exp_n-1]), int'({1'b1, 8'h09, 8'h08}));
            if (!ext)
                chk(log_ops[1] == {1'b1, 8'h30, 8'h01}, "R3", "comparator write",
                    int'(log_ops[1]), int'({1'b1, 8'h30, 8'h01}));
        end
        chk(hold_err == 0, "R4", "request fields held until ack", hold_err, 0);
    endtask

    // vector: {kind, ext, susp_delay[7:0]}
    localparam logic [9:0] VECS [6] = '{
        {1'b0, 1'b0, 8'd2},
        {1'b0, 1'b1, 8'd5},
        {1'b1, 1'b0, 8'd1},
        {1'b1, 1'b1, 8'd3},
        {1'b0, 1'b0, 8'd200},
        {1'b1, 1'b1, 8'd200}
    };

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_stamps();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(src_clk_en && periph_clk_en && core_clk_en && bus_clk_en, "R1", "clocks on", 0, 1);
        chk(!retain_en && rail_hpm && vdig_floor_hi, "R1", "rails/retention", int'(retain_en), 0);
        chk(!cmd_async_irq && !cmd_stop && !in_lpm && !phy_lpm_req && !reg_req && !entry_fail,
            "R1", "control bits clear", int'(in_lpm), 0);
        chk(wake_irq_en, "R1", "wake irq enabled", int'(wake_irq_en), 1);

        // R12 wake while active ignored
        clear_stamps();
        pulse(wake_evt);
        repeat (10) @(negedge clk);
        chk(!in_lpm && src_clk_en && periph_clk_en && nlog == 0 && t_cmd_on < 0,
            "R12", "wake in active ignored", int'(in_lpm), 0);

        foreach (VECS[v]) begin
            bit kind = VECS[v][9];
            bit ext  = VECS[v][8];
            bit ret_path = kind && ext;
            susp_delay = int'(VECS[v][7:0]);
            hold_err = 0;
            @(negedge clk); phy_kind = kind; ctrl_ext = ext;
            clear_stamps();
            pulse(suspend_req);
            wait_entry_end();
            check_reg_log(kind, ext);
            if (susp_delay > WAIT) begin
                chk(fail_seen, "R6", "abort reported", int'(fail_seen), 1);
                chk(!in_lpm && src_clk_en && periph_clk_en && core_clk_en && bus_clk_en,
                    "R6", "clocks restored, not in lpm", int'(in_lpm), 0);
                chk(!phy_lpm_req && wake_irq_en && !cmd_stop, "R6", "abort cleanup",
                    int'(phy_lpm_req), 0);
                continue;
            end
            chk(!fail_seen && in_lpm, "R5", "entered after phy_susp", int'(in_lpm), 1);
            chk(t_cmd_on >= 0 && t_cmd_on < t_per_off, "R7", "cmd bits before gating",
                t_cmd_on, t_per_off - 1);
            chk(t_per_off < t_src_off, "R7", "source clock gated last", t_src_off, t_per_off + 1);
            chk(!src_clk_en && !core_clk_en && !bus_clk_en && t_lpm_on >= t_src_off,
                "R9", "in_lpm after all clocks gated", t_lpm_on, t_src_off);
            if (ret_path) begin
                chk(t_ret_on >= 0 && t_ret_on < t_per_off, "R8", "retention before gating",
                    t_ret_on, t_per_off - 1);
                chk(t_rail_off > t_src_off && t_vdig_off > t_rail_off, "R8", "rails lowered after gating",
                    t_rail_off, t_src_off + 1);
            end else begin
                chk(t_ret_on < 0 && rail_hpm && vdig_floor_hi, "R8", "retention/rails untouched",
                    t_ret_on, -1);
            end

            // R12 suspend while in lpm ignored
            clear_stamps();
            pulse(suspend_req);
            repeat (10) @(negedge clk);
            chk(in_lpm && nlog == 0 && t_src_on < 0 && !src_clk_en, "R12", "suspend in lpm ignored",
                nlog, 0);

            // R13 scramble config in lpm
            if (ret_path) begin
                @(negedge clk); phy_kind = 1'b0; ctrl_ext = 1'b0;
            end

            clear_stamps();
            pulse(wake_evt);
            wait_exit_end();
            chk(t_src_on >= 0 && t_src_on < t_per_on, "R10", "source clock first on exit",
                t_src_on, t_per_on - 1);
            if (ret_path) begin
                chk(t_rail_on >= 0 && t_vdig_on >= 0 && t_ret_off > t_vdig_on && t_ret_off > t_rail_on,
                    "R10", "rails before retention clear", t_ret_off, t_vdig_on + 1);
                chk(t_ret_off >= 0 && !retain_en && nlog == 0, "R13", "exit uses captured config",
                    t_ret_off, 1);
            end
            chk(t_cmd_off >= 0 && t_cmd_off <= t_lpm_off, "R11", "cmd bits clear before flag",
                t_cmd_off, t_lpm_off);
            chk(t_lpm_off >= 0 && t_irq_on > t_lpm_off, "R11", "irq re-armed after flag clears",
                t_irq_on, t_lpm_off + 1);
            chk(src_clk_en && periph_clk_en && core_clk_en && bus_clk_en && rail_hpm && vdig_floor_hi,
                "R10", "all restored after exit", int'(src_clk_en), 1);
            chk(!in_lpm && wake_irq_en, "R9", "at rest after exit", int'(wake_irq_en), 1);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule